// File: doc/BRIEF.md
# Direct-Mapped Instruction Fetch Cache

This block sits between a 32-bit processor fetch port and a word-wide memory read port. The processor offers a fetch address with a request strobe. The block accepts the address while it is idle and later answers with a one-cycle response pulse that carries the 32-bit instruction word. Fetches from the two cacheable regions are looked up in a direct-mapped store that holds one tag and one data word per entry. A miss refills the whole four-word line from memory, one word after another. Fetches from any other region, and all fetches while the cache is switched off, go straight to memory as a single read.

The store has no separate valid bits. An entry whose tag is all ones counts as empty, and reset or the flush input writes all ones into every entry. Because the top address byte is not part of the tag, the two cacheable regions share the same lines. Entries keep their contents when memory changes underneath them, until a flush clears them.

Top module: `ifc_fetch_cache`

## Requirements
- R1: A fetch is cacheable when `cache_en` is 1 and address bits [31:24] are 0x00 or 0x80. A cacheable fetch hits when the tag stored at index `req_addr[11:2]` equals `req_addr[23:0]`. A hit raises `resp_valid` in the cycle after acceptance, with the stored word, and issues no memory read.
- R2: A cacheable miss issues exactly four memory reads at the line base (`req_addr & ~0xF`), then base+4, base+8 and base+12, in that order. Each read completes on a cycle where `mem_ready` is 1, and `mem_addr` is held stable while `mem_ready` is 0.
- R3: After a miss, `resp_valid` rises in the cycle after the fourth `mem_ready`, carrying the requested word. Later fetches to any word of that line hit.
- R4: A fetch from any other region issues one memory read at the exact address and responds in the cycle after `mem_ready`. Nothing is stored, so repeating the fetch reads memory again.
- R5: Tags ignore address bits [31:24], so a line filled through the 0x80 region hits through the 0x00 region. Two cacheable addresses with equal bits [11:2] and different tags evict each other.
- R6: While `cache_en` is 0, every fetch takes the single-read bypass path of R4, even when its line is stored.
- R7: Reset and a one-cycle `flush` make every entry empty (tag all ones). Until then, stored words are returned even if memory has changed.
- R8: A `flush` during a refill or bypass read aborts it. No response is given for that fetch, `mem_req` is 0 in the following cycle, and every line is empty afterwards.
- R9: `req_ready` is 1 only while the block is idle and `flush` is 0. Out of reset, `req_ready` is 1 and `resp_valid` and `mem_req` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cache_en | input | 1 | 1 enables caching; 0 forces bypass |
| flush | input | 1 | Invalidates every entry; aborts a pending read |
| req_valid | input | 1 | Fetch request strobe |
| req_addr | input | 32 | Word-aligned fetch address |
| req_ready | output | 1 | Request accepted at this edge when high with req_valid |
| resp_valid | output | 1 | One-cycle response strobe |
| resp_data | output | 32 | Instruction word for the response |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | 32 | Memory read word address |
| mem_ready | input | 1 | Memory read completes this cycle |
| mem_rdata | input | 32 | Memory read data, valid with mem_ready |

## Verification
Each result has a fixed due cycle. A hit answers one cycle after acceptance. A bypass read answers one cycle after its single `mem_ready`. A refill answers one cycle after its fourth `mem_ready`, so with the bench memory's one-cycle wait state the latencies are 1, 3 and 9 cycles. The bench counts falling edges from the acceptance edge to the response, checks that count against those figures, and records every memory read, so that read counts and address order are compared as well. The flush-abort case is checked on the falling edge right after the flush pulse, where both strobes must already be low.

// File: rtl/ifc_pkg.sv
package ifc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_FILL = 2'd1,
        ST_PASS = 2'd2
    } ifc_state_e;

endpackage

// File: rtl/ifc_region.sv
module ifc_region #(
    parameter int unsigned           REGION_W  = 8,
    parameter int unsigned           N_REGIONS = 2,
    parameter logic [N_REGIONS*REGION_W-1:0] REGION_IDS = {8'h80, 8'h00}
) (
    input  logic [REGION_W-1:0] top_bits_i,
    input  logic                enable_i,
    output logic                cacheable_o
);
    logic [N_REGIONS-1:0] match;

    for (genvar g = 0; g < N_REGIONS; g++) begin : g_region
        assign match[g] = (top_bits_i == REGION_IDS[g*REGION_W +: REGION_W]);
    end

    assign cacheable_o = enable_i && (|match);

endmodule

// File: rtl/ifc_store.sv
module ifc_store #(
    parameter int unsigned INDEX_W = 10,
    parameter int unsigned TAG_W   = 24,
    parameter int unsigned DATA_W  = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr_i,
    input  logic               we_i,
    input  logic [INDEX_W-1:0] wr_idx_i,
    input  logic [TAG_W-1:0]   wr_tag_i,
    input  logic [DATA_W-1:0]  wr_data_i,
    input  logic [INDEX_W-1:0] rd_idx_i,
    output logic [TAG_W-1:0]   rd_tag_o,
    output logic [DATA_W-1:0]  rd_data_o
);
    localparam int unsigned DEPTH = 1 << INDEX_W;

    logic [TAG_W-1:0]  tag_q  [DEPTH];
    logic [DATA_W-1:0] word_q [DEPTH];

    // All-ones tags mark empty entries; no separate valid bits.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                tag_q[i]  <= '1;
                word_q[i] <= '1;
            end
        end else if (clr_i) begin
            for (int i = 0; i < DEPTH; i++) begin
                tag_q[i]  <= '1;
                word_q[i] <= '1;
            end
        end else if (we_i) begin
            tag_q[wr_idx_i]  <= wr_tag_i;
            word_q[wr_idx_i] <= wr_data_i;
        end
    end

    assign rd_tag_o  = tag_q[rd_idx_i];
    assign rd_data_o = word_q[rd_idx_i];

    AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (rd_tag_o == '1)); // R7

endmodule

// File: rtl/ifc_ctrl.sv
module ifc_ctrl
    import ifc_pkg::*;
#(
    parameter int unsigned ADDR_W     = 32,
    parameter int unsigned DATA_W     = 32,
    parameter int unsigned LINE_OFF_W = 4,
    parameter int unsigned BYTE_OFF_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush_i,
    input  logic              req_valid_i,
    input  logic [ADDR_W-1:0] req_addr_i,
    input  logic              cacheable_i,
    input  logic              hit_i,
    input  logic [DATA_W-1:0] hit_data_i,
    input  logic              mem_ready_i,
    input  logic [DATA_W-1:0] mem_rdata_i,
    output logic              req_ready_o,
    output logic              resp_valid_o,
    output logic [DATA_W-1:0] resp_data_o,
    output logic              mem_req_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic              fill_we_o
);
    localparam int unsigned WPL_W      = LINE_OFF_W - BYTE_OFF_W;
    localparam int unsigned WORD_BYTES = 1 << BYTE_OFF_W;

    typedef struct packed {
        ifc_state_e        st;
        logic [ADDR_W-1:0] base;
        logic [WPL_W-1:0]  cnt;
        logic [WPL_W-1:0]  want;
        logic [DATA_W-1:0] keep;
        logic              rv;
        logic [DATA_W-1:0] rdat;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    always_comb begin
        ctl_d    = ctl_q;
        ctl_d.rv = 1'b0;

        req_ready_o = (ctl_q.st == ST_IDLE) && !flush_i;
        mem_req_o   = (ctl_q.st != ST_IDLE);
        mem_addr_o  = ctl_q.base;
        fill_we_o   = (ctl_q.st == ST_FILL) && mem_ready_i && !flush_i;

        if (flush_i) begin
            ctl_d.st = ST_IDLE;
        end else begin
            unique case (ctl_q.st)
                ST_IDLE: begin
                    if (req_valid_i) begin
                        if (hit_i) begin
                            ctl_d.rv   = 1'b1;
                            ctl_d.rdat = hit_data_i;
                        end else if (cacheable_i) begin
                            ctl_d.st   = ST_FILL;
                            ctl_d.base = {req_addr_i[ADDR_W-1:LINE_OFF_W], {LINE_OFF_W{1'b0}}};
                            ctl_d.cnt  = '0;
                            ctl_d.want = req_addr_i[LINE_OFF_W-1:BYTE_OFF_W];
                        end else begin
                            ctl_d.st   = ST_PASS;
                            ctl_d.base = req_addr_i;
                        end
                    end
                end
                ST_FILL: begin
                    if (mem_ready_i) begin
                        if (ctl_q.cnt == ctl_q.want) begin
                            ctl_d.keep = mem_rdata_i;
                        end
                        ctl_d.base = ctl_q.base + ADDR_W'(WORD_BYTES);
                        ctl_d.cnt  = ctl_q.cnt + 1'b1;
                        if (ctl_q.cnt == {WPL_W{1'b1}}) begin
                            ctl_d.st   = ST_IDLE;
                            ctl_d.rv   = 1'b1;
                            ctl_d.rdat = (ctl_q.cnt == ctl_q.want) ? mem_rdata_i : ctl_q.keep;
                        end
                    end
                end
                ST_PASS: begin
                    if (mem_ready_i) begin
                        ctl_d.st   = ST_IDLE;
                        ctl_d.rv   = 1'b1;
                        ctl_d.rdat = mem_rdata_i;
                    end
                end
                default: ctl_d.st = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{st: ST_IDLE, default: '0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign resp_valid_o = ctl_q.rv;
    assign resp_data_o  = ctl_q.rdat;

    AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && !mem_ready_i && !flush_i) |=> (mem_req_o && $stable(mem_addr_o))); // R2

    AST_FILL_ASCENDS: assert property (@(posedge clk) disable iff (!rst_n)
        ((ctl_q.st == ST_FILL) && mem_ready_i && !flush_i && (ctl_q.cnt != {WPL_W{1'b1}}))
        |=> (mem_addr_o == $past(mem_addr_o) + ADDR_W'(WORD_BYTES))); // R2

    AST_FLUSH_ABORTS: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |=> (!mem_req_o && !resp_valid_o)); // R8

endmodule

// File: rtl/ifc_fetch_cache.sv
module ifc_fetch_cache #(
    parameter int unsigned ADDR_W      = 32,
    parameter int unsigned DATA_W      = 32,
    parameter int unsigned CACHE_BYTES = 4096,
    parameter int unsigned LINE_BYTES  = 16,
    parameter int unsigned TAG_W       = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cache_en,
    input  logic              flush,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              req_ready,
    output logic              resp_valid,
    output logic [DATA_W-1:0] resp_data,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_ready,
    input  logic [DATA_W-1:0] mem_rdata
);
    localparam int unsigned WORD_BYTES = DATA_W / 8;
    localparam int unsigned BYTE_OFF_W = $clog2(WORD_BYTES);
    localparam int unsigned LINE_OFF_W = $clog2(LINE_BYTES);
    localparam int unsigned DEPTH      = CACHE_BYTES / WORD_BYTES;
    localparam int unsigned INDEX_W    = $clog2(DEPTH);
    localparam int unsigned REGION_W   = ADDR_W - TAG_W;

    logic              cacheable;
    logic              hit;
    logic              fill_we;
    logic [TAG_W-1:0]  rd_tag;
    logic [DATA_W-1:0] rd_data;

    ifc_region #(
        .REGION_W  (REGION_W),
        .N_REGIONS (2),
        .REGION_IDS({REGION_W'(8'h80), REGION_W'(8'h00)})
    ) u_region (
        .top_bits_i (req_addr[ADDR_W-1:TAG_W]),
        .enable_i   (cache_en),
        .cacheable_o(cacheable)
    );

    ifc_store #(
        .INDEX_W(INDEX_W),
        .TAG_W  (TAG_W),
        .DATA_W (DATA_W)
    ) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_i    (flush),
        .we_i     (fill_we),
        .wr_idx_i (mem_addr[BYTE_OFF_W +: INDEX_W]),
        .wr_tag_i (mem_addr[TAG_W-1:0]),
        .wr_data_i(mem_rdata),
        .rd_idx_i (req_addr[BYTE_OFF_W +: INDEX_W]),
        .rd_tag_o (rd_tag),
        .rd_data_o(rd_data)
    );

    assign hit = cacheable && (rd_tag == req_addr[TAG_W-1:0]);

    ifc_ctrl #(
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W),
        .LINE_OFF_W(LINE_OFF_W),
        .BYTE_OFF_W(BYTE_OFF_W)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .flush_i     (flush),
        .req_valid_i (req_valid),
        .req_addr_i  (req_addr),
        .cacheable_i (cacheable),
        .hit_i       (hit),
        .hit_data_i  (rd_data),
        .mem_ready_i (mem_ready),
        .mem_rdata_i (mem_rdata),
        .req_ready_o (req_ready),
        .resp_valid_o(resp_valid),
        .resp_data_o (resp_data),
        .mem_req_o   (mem_req),
        .mem_addr_o  (mem_addr),
        .fill_we_o   (fill_we)
    );

    AST_HIT_ANSWERS: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && hit) |=> (resp_valid && resp_data == $past(rd_data))); // R1

    AST_HIT_NO_MEM: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && hit) |=> !mem_req); // R1

endmodule

// File: tb/ifc_fetch_cache_test.sv
module ifc_fetch_cache_test;
    localparam int WAIT     = 1;
    localparam int LAT_HIT  = 1;
    localparam int LAT_PASS = WAIT + 2;
    localparam int LAT_FILL = 4 * (WAIT + 1) + 1;
    localparam logic [31:0] KEY = 32'h5A3C_96F0;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cache_en = 1'b1;
    logic        flush = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic        req_ready;
    logic        resp_valid;
    logic [31:0] resp_data;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic        mem_ready = 1'b0;
    logic [31:0] mem_rdata;

    int          checks = 0;
    int          fails  = 0;
    bit          done   = 1'b0;
    logic [31:0] gen    = '0;
    int          wcnt   = 0;
    int          n_mem  = 0;
    logic [31:0] mlog [64];

    always #5 clk = ~clk;

    ifc_fetch_cache uut (
        .clk(clk), .rst_n(rst_n), .cache_en(cache_en), .flush(flush),
        .req_valid(req_valid), .req_addr(req_addr), .req_ready(req_ready),
        .resp_valid(resp_valid), .resp_data(resp_data),
        .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_ready(mem_ready), .mem_rdata(mem_rdata)
    );

    function automatic logic [31:0] word_of(input logic [31:0] a, input logic [31:0] g);
        return a ^ KEY ^ g;
    endfunction

    assign mem_rdata = word_of(mem_addr, gen);

    // Memory model: one wait state, then ready for one cycle.
    always @(negedge clk) begin
        if (mem_req && wcnt == WAIT) begin
            mem_ready <= 1'b1;
            mlog[n_mem % 64] = mem_addr;
            n_mem++;
            wcnt = 0;
        end else begin
            mem_ready <= 1'b0;
            wcnt = mem_req ? wcnt + 1 : 0;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic fetch(input logic [31:0] a, input int reads, input int lat_exp,
                         input logic [31:0] dexp, input string req);
        int n0;
        int lat;
        @(negedge clk);
        req_valid = 1'b1;
        req_addr  = a;
        n0 = n_mem;
        #1;
        while (!req_ready) begin
            @(negedge clk);
            #1;
        end
        @(negedge clk);
        req_valid = 1'b0;
        lat = 1;
        while (!resp_valid && lat < 40) begin
            @(negedge clk);
            lat++;
        end
        chk(resp_valid && resp_data == dexp, req, resp_data, dexp);
        chk(lat == lat_exp, req, lat, lat_exp);
        chk(n_mem - n0 == reads, req, n_mem - n0, reads);
        if (reads == 4) begin
            for (int i = 0; i < 4; i++) begin
                chk(mlog[(n0 + i) % 64] == ((a & ~32'hF) + 32'(4 * i)), "R2",
                    mlog[(n0 + i) % 64], (a & ~32'hF) + 32'(4 * i));
            end
        end else if (reads == 1) begin
            chk(mlog[n0 % 64] == a, "R4", mlog[n0 % 64], a);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 10);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual %h expected %h", 32'd1, 32'd0);
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(!resp_valid && !mem_req, "R9 reset strobes", {resp_valid, mem_req}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        chk(req_ready == 1'b1, "R9 ready after reset", req_ready, 1);

        // Sweep: eight lines, miss on one word then hits on all four (R2, R3, R1).
        for (int ln = 0; ln < 8; ln++) begin
            logic [31:0] base;
            logic [31:0] first;
            base  = 32'h8000_0000 + 32'(ln * 16);
            first = base + 32'((ln % 4) * 4);
            fetch(first, 4, LAT_FILL, word_of(first, 0), "R3 miss refill");
            for (int w = 0; w < 4; w++) begin
                fetch(base + 32'(4 * w), 0, LAT_HIT, word_of(base + 32'(4 * w), 0), "R1 hit");
            end
        end

        // Alias through region 0x00 (R5).
        fetch(32'h0000_0018, 0, LAT_HIT, word_of(32'h8000_0018, 0), "R5 alias hit");

        // Index conflict (R5).
        fetch(32'h8000_1008, 4, LAT_FILL, word_of(32'h8000_1008, 0), "R5 conflict miss");
        fetch(32'h8000_0008, 4, LAT_FILL, word_of(32'h8000_0008, 0), "R5 evicted miss");

        // Uncached region (R4).
        fetch(32'hBFC0_0100, 1, LAT_PASS, word_of(32'hBFC0_0100, 0), "R4 bypass");
        fetch(32'hBFC0_0100, 1, LAT_PASS, word_of(32'hBFC0_0100, 0), "R4 bypass repeat");

        // Cache disabled (R6).
        cache_en = 1'b0;
        fetch(32'h8000_0008, 1, LAT_PASS, word_of(32'h8000_0008, 0), "R6 disabled bypass");
        cache_en = 1'b1;
        fetch(32'h8000_0008, 0, LAT_HIT, word_of(32'h8000_0008, 0), "R6 re-enabled hit");

        // Stale contents until flush (R7).
        gen = 32'h00FF_00FF;
        fetch(32'h8000_0004, 0, LAT_HIT, word_of(32'h8000_0004, 0), "R7 stale hit");
        @(negedge clk);
        flush = 1'b1;
        #1;
        chk(req_ready == 1'b0, "R9 ready low in flush", req_ready, 0);
        @(negedge clk);
        flush = 1'b0;
        fetch(32'h8000_0004, 4, LAT_FILL, word_of(32'h8000_0004, gen), "R7 miss after flush");

        // Flush during refill (R8).
        @(negedge clk);
        req_valid = 1'b1;
        req_addr  = 32'h8000_2000;
        @(negedge clk);
        req_valid = 1'b0;
        #1;
        chk(req_ready == 1'b0, "R9 ready low in refill", req_ready, 0);
        repeat (2) @(negedge clk);
        flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
        chk(!mem_req && !resp_valid, "R8 abort strobes", {mem_req, resp_valid}, 0);
        repeat (3) begin
            @(negedge clk);
            chk(!resp_valid, "R8 no response", resp_valid, 0);
        end
        fetch(32'h8000_2000, 4, LAT_FILL, word_of(32'h8000_2000, gen), "R8 line empty");
        fetch(32'h8000_0004, 4, LAT_FILL, word_of(32'h8000_0004, gen), "R8 all lines empty");

        finish_run();
    end

endmodule